// File: doc/BRIEF.md
# Block Cipher Chaining-Mode Unit

This unit sits between a data stream and an external block cipher core and turns that core into one of four chaining modes: electronic codebook, counter, cipher feedback or cipher block chaining. Encryption and decryption both pass through a single datapath. A single input channel carries plaintext or ciphertext, and a single output channel returns the result. The unit owns the chaining-state register and does the XOR and feedback steps. It drives the core over a request/response port that carries a direction flag, so the core can apply either its forward or its inverse transform. The unit also counts the blocks it delivers.

A user first loads an initial value while the unit is idle, then streams blocks with valid/ready flow control. Only one block is in flight at a time. The mode and direction are sampled when a block is accepted. Each result is held until the consumer takes it, and the chaining state moves only at that moment.

Top module: `blk_mode_unit`

## Requirements
- R1: After reset, bdi_ready is 1, bdo_valid and core_req_valid are 0, blk_count is 0, and the chaining state is all zeros. With no initial value loaded, the first counter-mode block returns input XOR fwd(0).
- R2: Mode code 0 is codebook. Each output is fwd(input) when cfg_decrypt is 0 and inv(input) when it is 1. The state does not change.
- R3: Mode code 1 is counter. The core receives the state with core_req_inverse at 0, the output is input XOR fwd(state), and the state then increases by one, wrapping modulo 2^BLK_W across the full width.
- R4: In counter mode and in feedback mode, core_req_inverse stays 0 whatever the direction, so counter decryption of a counter-mode ciphertext gives back the plaintext.
- R5: Mode code 2 is cipher feedback. The output is input XOR fwd(state). The next state is the ciphertext block: the output when encrypting, the input when decrypting.
- R6: Mode code 3 with cfg_decrypt at 0 is chaining encryption. The output is fwd(input XOR state), and that output becomes the next state.
- R7: Mode code 3 with cfg_decrypt at 1 is chaining decryption. The output is inv(input) XOR state, and the input becomes the next state.
- R8: bdi_ready is 1 only when no block is in flight and iv_load is low. Between the acceptance of a block and the acceptance of its result, no further block is taken.
- R9: While bdo_valid is 1 and bdo_ready is 0, bdo_data holds its value. The chaining state changes only when the result is accepted.
- R10: iv_load, cfg_mode and cfg_decrypt have no effect on a block already accepted. iv_load is taken only while idle, and a taken load sets the state to iv_data.
- R11: blk_count increases by one on each accepted result and returns to 0 when an initial value is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Mode code: 0 codebook, 1 counter, 2 feedback, 3 chaining |
| cfg_decrypt | input | 1 | 1 selects decryption |
| iv_load | input | 1 | Load iv_data into the state (taken only when idle) |
| iv_data | input | BLK_W | Initial value |
| bdi_valid | input | 1 | Input block valid |
| bdi_ready | output | 1 | Input block can be taken |
| bdi_data | input | BLK_W | Input block |
| bdo_valid | output | 1 | Result valid |
| bdo_ready | input | 1 | Consumer takes result |
| bdo_data | output | BLK_W | Result block |
| core_req_valid | output | 1 | Request to the cipher core |
| core_req_ready | input | 1 | Core takes the request |
| core_req_inverse | output | 1 | 1 requests the inverse transform |
| core_req_data | output | BLK_W | Block for the core |
| core_rsp_valid | input | 1 | One-cycle pulse with the core result |
| core_rsp_data | input | BLK_W | Core result |
| blk_count | output | CNT_W | Results delivered since the last load |

## Verification
The hardest case to reach is a result stalled at the output while the configuration inputs and the load strobe change under it. A correct unit must keep the held block, the state and the later chaining all untouched. The stimulus reaches this by accepting a block, then flipping the mode and direction and raising iv_load during the core wait and during a held output. It then checks both the stalled result and the next block, which depends on the state. A counter run that starts one below the all-ones value drives the increment across its full-width wrap. Round trips in each mode show that the direction flag reaches the core correctly.

// File: rtl/blk_mode_pkg.sv
package blk_mode_pkg;

   typedef enum logic [1:0] {
      MODE_ECB = 2'd0,
      MODE_CTR = 2'd1,
      MODE_CFB = 2'd2,
      MODE_CBC = 2'd3
   } chain_mode_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_REQ  = 2'd1,
      PH_WAIT = 2'd2,
      PH_OUT  = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      NX_HOLD = 2'd0,
      NX_INC  = 2'd1,
      NX_IN   = 2'd2,
      NX_OUT  = 2'd3
   } nxt_sel_e;

   function automatic logic wants_inverse(input chain_mode_e m, input logic dec);
      return dec && (m == MODE_ECB || m == MODE_CBC);
   endfunction

endpackage

// File: rtl/blk_mode_ctrl.sv
module blk_mode_ctrl
   import blk_mode_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic bdi_valid,
   input  logic iv_load,
   input  logic core_req_ready,
   input  logic core_rsp_valid,
   input  logic bdo_ready,
   output logic bdi_ready,
   output logic take_blk,
   output logic take_iv,
   output logic core_req_valid,
   output logic take_rsp,
   output logic bdo_valid,
   output logic give_blk
);

   phase_e ph_q, ph_d;

   assign bdi_ready      = (ph_q == PH_IDLE) && !iv_load;
   assign take_blk       = bdi_ready && bdi_valid;
   assign take_iv        = (ph_q == PH_IDLE) && iv_load;
   assign core_req_valid = (ph_q == PH_REQ);
   assign take_rsp       = (ph_q == PH_WAIT) && core_rsp_valid;
   assign bdo_valid      = (ph_q == PH_OUT);
   assign give_blk       = bdo_valid && bdo_ready;

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE: if (take_blk)       ph_d = PH_REQ;
         PH_REQ:  if (core_req_ready) ph_d = PH_WAIT;
         PH_WAIT: if (core_rsp_valid) ph_d = PH_OUT;
         PH_OUT:  if (bdo_ready)      ph_d = PH_IDLE;
         default:                     ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   // R8: an accepted block blocks further input until its result leaves
   p_single_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take_blk |=> !bdi_ready && core_req_valid);

   p_rsp_to_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
      take_rsp |=> bdo_valid);

   p_out_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bdo_valid && !bdo_ready |=> bdo_valid);

endmodule

// File: rtl/blk_mode_path.sv
module blk_mode_path
   import blk_mode_pkg::*;
#(
   parameter int BLK_W = 128
) (
   input  chain_mode_e      mode,
   input  logic             dec,
   input  logic [BLK_W-1:0] din,
   input  logic [BLK_W-1:0] st,
   input  logic [BLK_W-1:0] rsp,
   output logic [BLK_W-1:0] req_data,
   output logic             req_inv,
   output logic [BLK_W-1:0] out_data,
   output nxt_sel_e         nxt_sel
);

   logic [BLK_W-1:0] din_mix;
   logic [BLK_W-1:0] rsp_mix;

   assign din_mix = din ^ st;
   assign req_inv = wants_inverse(mode, dec);

   always_comb begin
      unique case (mode)
         MODE_ECB: rsp_mix = rsp;
         MODE_CTR,
         MODE_CFB: rsp_mix = rsp ^ din;
         MODE_CBC: rsp_mix = dec ? (rsp ^ st) : rsp;
         default:  rsp_mix = rsp;
      endcase
   end

   always_comb begin
      unique case (mode)
         MODE_ECB: req_data = din;
         MODE_CTR,
         MODE_CFB: req_data = st;
         MODE_CBC: req_data = dec ? din : din_mix;
         default:  req_data = din;
      endcase
   end

   always_comb begin
      unique case (mode)
         MODE_ECB: nxt_sel = NX_HOLD;
         MODE_CTR: nxt_sel = NX_INC;
         MODE_CFB,
         MODE_CBC: nxt_sel = dec ? NX_IN : NX_OUT;
         default:  nxt_sel = NX_HOLD;
      endcase
   end

   assign out_data = rsp_mix;

endmodule

// File: rtl/blk_mode_state.sv
module blk_mode_state
   import blk_mode_pkg::*;
#(
   parameter int BLK_W  = 128,
   parameter int LANE_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_iv,
   input  logic [BLK_W-1:0] iv_data,
   input  logic             give_blk,
   input  nxt_sel_e         nxt_sel,
   input  logic [BLK_W-1:0] din,
   input  logic [BLK_W-1:0] dout,
   output logic [BLK_W-1:0] st,
   output logic [CNT_W-1:0] cnt
);

   localparam int LANES = BLK_W / LANE_W;

   logic [BLK_W-1:0] st_inc;
   logic [LANES:0]   carry;

   assign carry[0] = 1'b1;

   // Full-width increment built from lanes with a ripple carry between them.
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] lane;
      assign lane = st[g*LANE_W +: LANE_W];
      assign st_inc[g*LANE_W +: LANE_W] = lane + {{(LANE_W-1){1'b0}}, carry[g]};
      assign carry[g+1] = carry[g] & (&lane);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
      end else if (take_iv) begin
         st <= iv_data;
      end else if (give_blk) begin
         unique case (nxt_sel)
            NX_HOLD: st <= st;
            NX_INC:  st <= st_inc;
            NX_IN:   st <= din;
            NX_OUT:  st <= dout;
            default: st <= st;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (take_iv)  cnt <= '0;
      else if (give_blk) cnt <= cnt + 1'b1;
   end

   // R9: chaining state is quiet unless a result is taken or a load happens
   p_state_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !give_blk && !take_iv |=> $stable(st));

   // R3: counter step across the full width, wrapping at the top
   p_ctr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      give_blk && !take_iv && nxt_sel == NX_INC |=> st == $past(st) + 1'b1);

   // R10: a taken load places the initial value
   p_iv_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
      take_iv |=> st == $past(iv_data) && cnt == '0);

   // R11: one count per delivered block
   p_cnt_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      give_blk && !take_iv |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/blk_mode_unit.sv
module blk_mode_unit
   import blk_mode_pkg::*;
#(
   parameter int BLK_W  = 128,
   parameter int LANE_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_mode,
   input  logic             cfg_decrypt,
   input  logic             iv_load,
   input  logic [BLK_W-1:0] iv_data,
   input  logic             bdi_valid,
   output logic             bdi_ready,
   input  logic [BLK_W-1:0] bdi_data,
   output logic             bdo_valid,
   input  logic             bdo_ready,
   output logic [BLK_W-1:0] bdo_data,
   output logic             core_req_valid,
   input  logic             core_req_ready,
   output logic             core_req_inverse,
   output logic [BLK_W-1:0] core_req_data,
   input  logic             core_rsp_valid,
   input  logic [BLK_W-1:0] core_rsp_data,
   output logic [CNT_W-1:0] blk_count
);

   if (BLK_W < 8) begin : g_chk_blk
      $error("BLK_W must be at least 8");
   end
   if (LANE_W < 1 || (BLK_W % LANE_W) != 0) begin : g_chk_lane
      $error("LANE_W must divide BLK_W");
   end
   if (CNT_W < 1) begin : g_chk_cnt
      $error("CNT_W must be positive");
   end

   logic             take_blk, take_iv, take_rsp, give_blk;
   chain_mode_e      mode_q;
   logic             dec_q;
   logic [BLK_W-1:0] din_q;
   logic [BLK_W-1:0] out_q;
   logic [BLK_W-1:0] st;
   logic [BLK_W-1:0] out_calc;
   nxt_sel_e         nxt_sel;

   blk_mode_ctrl u_ctrl (
      .clk            (clk),
      .rst_n          (rst_n),
      .bdi_valid      (bdi_valid),
      .iv_load        (iv_load),
      .core_req_ready (core_req_ready),
      .core_rsp_valid (core_rsp_valid),
      .bdo_ready      (bdo_ready),
      .bdi_ready      (bdi_ready),
      .take_blk       (take_blk),
      .take_iv        (take_iv),
      .core_req_valid (core_req_valid),
      .take_rsp       (take_rsp),
      .bdo_valid      (bdo_valid),
      .give_blk       (give_blk)
   );

   // Block, mode and direction are frozen for the whole flight (R10)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_ECB;
         dec_q  <= 1'b0;
         din_q  <= '0;
      end else if (take_blk) begin
         mode_q <= chain_mode_e'(cfg_mode);
         dec_q  <= cfg_decrypt;
         din_q  <= bdi_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        out_q <= '0;
      else if (take_rsp) out_q <= out_calc;
   end

   blk_mode_path #(.BLK_W(BLK_W)) u_path (
      .mode     (mode_q),
      .dec      (dec_q),
      .din      (din_q),
      .st       (st),
      .rsp      (core_rsp_data),
      .req_data (core_req_data),
      .req_inv  (core_req_inverse),
      .out_data (out_calc),
      .nxt_sel  (nxt_sel)
   );

   blk_mode_state #(.BLK_W(BLK_W), .LANE_W(LANE_W), .CNT_W(CNT_W)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_iv  (take_iv),
      .iv_data  (iv_data),
      .give_blk (give_blk),
      .nxt_sel  (nxt_sel),
      .din      (din_q),
      .dout     (out_q),
      .st       (st),
      .cnt      (blk_count)
   );

   assign bdo_data = out_q;

   // R9: a stalled result keeps its value
   p_bdo_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bdo_valid && !bdo_ready |=> bdo_valid && $stable(bdo_data));

   // R8: a pending request is held steady until the core takes it
   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      core_req_valid && !core_req_ready |=> core_req_valid && $stable(core_req_data)
                                            && $stable(core_req_inverse));

   // R4: counter and feedback modes never ask for the inverse transform
   p_fwd_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      core_req_valid && (mode_q == MODE_CTR || mode_q == MODE_CFB) |-> !core_req_inverse);

   // R10: configuration inputs do not reach a block in flight
   p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bdi_ready && !take_iv && (core_req_valid || bdo_valid) |=> $stable(mode_q) && $stable(dec_q));

endmodule

// File: tb/blk_mode_unit_tb.sv
module blk_mode_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int W = 128;
   localparam logic [W-1:0] KEY = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;

   logic          clk = 0;
   logic          rst_n = 0;
   logic [1:0]    cfg_mode = 0;
   logic          cfg_decrypt = 0;
   logic          iv_load = 0;
   logic [W-1:0]  iv_data = '0;
   logic          bdi_valid = 0;
   logic          bdi_ready;
   logic [W-1:0]  bdi_data = '0;
   logic          bdo_valid;
   logic          bdo_ready = 0;
   logic [W-1:0]  bdo_data;
   logic          core_req_valid;
   logic          core_req_ready = 0;
   logic          core_req_inverse;
   logic [W-1:0]  core_req_data;
   logic          core_rsp_valid = 0;
   logic [W-1:0]  core_rsp_data = '0;
   logic [15:0]   blk_count;

   always #(CLK_PERIOD/2) clk = ~clk;

   blk_mode_unit u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_decrypt(cfg_decrypt),
      .iv_load(iv_load), .iv_data(iv_data), .bdi_valid(bdi_valid), .bdi_ready(bdi_ready),
      .bdi_data(bdi_data), .bdo_valid(bdo_valid), .bdo_ready(bdo_ready), .bdo_data(bdo_data),
      .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
      .core_req_inverse(core_req_inverse), .core_req_data(core_req_data),
      .core_rsp_valid(core_rsp_valid), .core_rsp_data(core_rsp_data), .blk_count(blk_count)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // stand-in keyed reversible core
   function automatic logic [W-1:0] fwd(input logic [W-1:0] x);
      logic [W-1:0] t;
      t = x ^ KEY;
      return {t[W-8:0], t[W-1:W-7]};
   endfunction

   function automatic logic [W-1:0] inv(input logic [W-1:0] y);
      logic [W-1:0] t;
      t = {y[6:0], y[W-1:7]};
      return t ^ KEY;
   endfunction

   // reference model from the requirements
   function automatic logic [W-1:0] m_out(input logic [1:0] m, input logic d,
                                          input logic [W-1:0] x, input logic [W-1:0] s);
      case (m)
         2'd0:    return d ? inv(x) : fwd(x);
         2'd1,
         2'd2:    return x ^ fwd(s);
         default: return d ? (inv(x) ^ s) : fwd(x ^ s);
      endcase
   endfunction

   function automatic logic [W-1:0] m_next(input logic [1:0] m, input logic d,
                                           input logic [W-1:0] x, input logic [W-1:0] s,
                                           input logic [W-1:0] o);
      case (m)
         2'd0:    return s;
         2'd1:    return s + 1;
         default: return d ? x : o;
      endcase
   endfunction

   function automatic logic [W-1:0] m_req(input logic [1:0] m, input logic d,
                                          input logic [W-1:0] x, input logic [W-1:0] s);
      case (m)
         2'd0:    return x;
         2'd1,
         2'd2:    return s;
         default: return d ? x : (x ^ s);
      endcase
   endfunction

   logic [W-1:0] ref_st = '0;
   logic [15:0]  ref_cnt = 0;
   logic [W-1:0] exp_req = '0;
   logic         exp_inv = 0;
   logic [W-1:0] last_out;

   // core model: request capture at the edge, replies driven at negedge
   int           hs_cnt = 0;
   int           srv_cnt = 0;
   int           wcnt = 0;
   int           core_delay = 0;
   logic [W-1:0] cap_d;
   logic         cap_inv;

   always @(posedge clk) begin
      if (rst_n && core_req_valid && core_req_ready) begin
         hs_cnt++;
         cap_d   = core_req_data;
         cap_inv = core_req_inverse;
         chk(core_req_data === exp_req, "R3/R6 core request data", core_req_data, exp_req);
         chk(core_req_inverse === exp_inv, "R4 core direction flag",
             {{(W-1){1'b0}}, core_req_inverse}, {{(W-1){1'b0}}, exp_inv});
      end
   end

   always @(negedge clk) begin
      logic rdy;
      rdy = 0;
      core_rsp_valid = 0;
      if (hs_cnt != srv_cnt) begin
         srv_cnt = hs_cnt;
         core_rsp_valid = 1;
         core_rsp_data = cap_inv ? inv(cap_d) : fwd(cap_d);
         wcnt = 0;
      end else if (core_req_valid && !core_req_ready) begin
         if (wcnt >= core_delay) rdy = 1;
         else wcnt++;
      end
      core_req_ready = rdy;
   end

   // per-clock monitor: input readiness and held output (R8, R9)
   bit           ref_busy = 0;
   bit           prev_hold = 0;
   logic [W-1:0] prev_bdo = '0;

   always @(posedge clk) begin
      if (rst_n) begin
         chk(bdi_ready === (!ref_busy && !iv_load), "R8 bdi_ready",
             {{(W-1){1'b0}}, bdi_ready}, {{(W-1){1'b0}}, (!ref_busy && !iv_load)});
         if (prev_hold)
            chk(bdo_valid === 1'b1 && bdo_data === prev_bdo, "R9 held result", bdo_data, prev_bdo);
         prev_hold = bdo_valid && !bdo_ready;
         prev_bdo  = bdo_data;
         if (bdi_valid && bdi_ready) ref_busy = 1;
         if (bdo_valid && bdo_ready) ref_busy = 0;
      end
   end

   task automatic load_iv(input logic [W-1:0] v);
      @(negedge clk);
      iv_load = 1; iv_data = v;
      @(negedge clk);
      iv_load = 0;
      ref_st = v; ref_cnt = 0;
      chk(blk_count === 16'd0, "R11 count cleared by load", {112'd0, blk_count}, '0);
   endtask

   task automatic xfer(input logic [W-1:0] din, input int stall, input bit disturb, input string tag);
      logic [W-1:0] eo;
      logic [1:0]   sv_mode;
      logic         sv_dec;
      sv_mode = cfg_mode; sv_dec = cfg_decrypt;
      eo      = m_out(cfg_mode, cfg_decrypt, din, ref_st);
      exp_req = m_req(cfg_mode, cfg_decrypt, din, ref_st);
      exp_inv = cfg_decrypt && (cfg_mode == 2'd0 || cfg_mode == 2'd3);
      @(negedge clk);
      bdi_valid = 1; bdi_data = din;
      @(negedge clk);
      bdi_valid = 0; bdi_data = ~din;
      if (disturb) begin
         cfg_mode = cfg_mode + 2'd1; cfg_decrypt = !cfg_decrypt;
         iv_load = 1; iv_data = ~ref_st;
      end
      while (!bdo_valid) @(negedge clk);
      repeat (stall) @(negedge clk);
      if (disturb) iv_load = 0;
      chk(bdo_data === eo, tag, bdo_data, eo);
      bdo_ready = 1;
      @(negedge clk);
      bdo_ready = 0;
      cfg_mode = sv_mode; cfg_decrypt = sv_dec;
      ref_st = m_next(sv_mode, sv_dec, din, ref_st, eo);
      ref_cnt++;
      last_out = eo;
      chk(blk_count === ref_cnt, "R11 delivered count", {112'd0, blk_count}, {112'd0, ref_cnt});
   endtask

   initial begin
      repeat (CLK_PERIOD * 1000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] pt [3];
      logic [W-1:0] ct [3];
      pt[0] = 128'h00112233_44556677_8899aabb_ccddeeff;
      pt[1] = 128'hdeadbeef_01234567_89abcdef_fedcba98;
      pt[2] = 128'h0;

      repeat (3) @(negedge clk);
      chk(bdi_ready === 1'b1 && bdo_valid === 1'b0 && core_req_valid === 1'b0,
          "R1 reset outputs", {125'd0, bdi_ready, bdo_valid, core_req_valid}, {125'd0, 3'b100});
      rst_n = 1;
      @(negedge clk);
      chk(blk_count === 16'd0, "R1 reset count", {112'd0, blk_count}, '0);

      // R1: zero state shows through counter mode without a load
      cfg_mode = 2'd1; cfg_decrypt = 0;
      xfer(pt[1], 0, 0, "R1 counter block from cleared state");
      chk(last_out === (pt[1] ^ fwd('0)), "R1 zero state keystream", last_out, pt[1] ^ fwd('0));

      // R2: codebook both ways
      cfg_mode = 2'd0; cfg_decrypt = 0; core_delay = 1;
      for (int i = 0; i < 2; i++) begin
         xfer(pt[i], 0, 0, "R2 codebook encrypt");
         ct[i] = last_out;
      end
      cfg_decrypt = 1;
      xfer(ct[0], 1, 0, "R2 codebook decrypt");
      chk(last_out === pt[0], "R2 codebook round trip", last_out, pt[0]);

      // R3: counter across full-width wrap
      cfg_mode = 2'd1; cfg_decrypt = 0; core_delay = 0;
      load_iv({W{1'b1}} - 1);
      for (int i = 0; i < 3; i++) begin
         xfer(pt[i], 0, 0, "R3 counter encrypt");
         ct[i] = last_out;
      end
      chk(ct[2] === (pt[2] ^ fwd('0)), "R3 wrapped counter", ct[2], pt[2] ^ fwd('0));
      // R4: counter decrypt with forward core
      cfg_decrypt = 1;
      load_iv({W{1'b1}} - 1);
      for (int i = 0; i < 3; i++) begin
         xfer(ct[i], 0, 0, "R4 counter decrypt");
         chk(last_out === pt[i], "R4 counter round trip", last_out, pt[i]);
      end

      // R5: feedback
      cfg_mode = 2'd2; cfg_decrypt = 0; core_delay = 2;
      load_iv(128'h13579bdf_2468ace0_fedcba98_76543210);
      for (int i = 0; i < 3; i++) begin
         xfer(pt[i], 0, 0, "R5 feedback encrypt");
         ct[i] = last_out;
      end
      cfg_decrypt = 1;
      load_iv(128'h13579bdf_2468ace0_fedcba98_76543210);
      for (int i = 0; i < 3; i++) begin
         xfer(ct[i], 0, 0, "R5 feedback decrypt");
         chk(last_out === pt[i], "R5 feedback round trip", last_out, pt[i]);
      end

      // R6 / R7: chaining
      cfg_mode = 2'd3; cfg_decrypt = 0; core_delay = 0;
      load_iv(128'hcafef00d_00000000_ffffffff_12345678);
      for (int i = 0; i < 3; i++) begin
         xfer(pt[i], 0, 0, "R6 chaining encrypt");
         ct[i] = last_out;
      end
      cfg_decrypt = 1;
      load_iv(128'hcafef00d_00000000_ffffffff_12345678);
      for (int i = 0; i < 3; i++) begin
         xfer(ct[i], 0, 0, "R7 chaining decrypt");
         chk(last_out === pt[i], "R7 chaining round trip", last_out, pt[i]);
      end

      // R9: stalled output in chaining encrypt, then follow-on block
      cfg_decrypt = 0; core_delay = 3;
      xfer(pt[0], 5, 0, "R9 stalled chaining result");
      xfer(pt[1], 0, 0, "R9 chain after stall");

      // R10: disturbance while busy, then dependent blocks
      cfg_mode = 2'd2; cfg_decrypt = 0; core_delay = 2;
      load_iv(128'h1);
      xfer(pt[1], 3, 1, "R10 feedback block under disturbance");
      xfer(pt[0], 0, 0, "R10 next block uses untouched state");
      cfg_mode = 2'd1;
      xfer(pt[2], 2, 1, "R10 counter block under disturbance");
      xfer(pt[2], 0, 0, "R10 counter state after disturbance");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule